// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock of an I2C bus master. It drives the SCL wire in open-drain fashion: `scl_oe` high means "pull the line low", and `scl_oe` low leaves the line to the pull-up. Each SCL period has a low phase and a high phase. The controller counts system-clock cycles for each phase against one of two programmable count pairs. One pair is for standard mode and one is for fast mode, and `speed_sel` picks the pair. A bit engine beside it uses the two midpoint strobes to change SDA while SCL is low and to sample SDA while SCL is high.

The low phase is timed from the cycle in which the block starts pulling SCL down, so the fall time of the wire comes out of the programmed low time. After release, the block does not time the high phase until it samples the wire high. A slow device that holds SCL low therefore stretches the period. The high phase carries a fixed overhead on top of its count: one cycle to see the line high and seven more counted cycles. The count registers have reset values derived from the system clock frequency. They can be rewritten only while the controller is disabled.

The controller is a four-state machine:
- IDLE releases SCL. It moves to LOW when `enable` and `run` are both high.
- LOW pulls SCL down. It moves to WAIT_HIGH after the low count expires.
- WAIT_HIGH releases SCL and waits. It moves to HIGH once `scl_in` reads 1.
- HIGH times the high phase. When the high count expires it returns to LOW if `run` is still high, or to IDLE if not.

Dropping `enable` forces IDLE from any state.

Top module: `scl_period_gen`

## Requirements
- R1: During and right after reset, `scl_oe`, `low_strobe` and `high_strobe` are 0.
- R2: There are four count registers, selected by `cfg_idx`: 0 = standard high, 1 = standard low, 2 = fast high, 3 = fast low. `cfg_we` loads `cfg_wdata` into the selected register only while `enable` is 0. A write while `enable` is 1 leaves the register unchanged.
- R3: After reset, each register holds (CLK_KHZ*T + 5000)/10000 - A, where T is in tenths of a microsecond. The high counts use T = target high + 3 fall and A = 3. The low counts use T = target low + 3 fall and A = 1. The targets are 40/47 tenths for standard mode and 6/13 tenths for fast mode. With CLK_KHZ = 10000 this gives 40, 49, 6 and 15.
- R4: Each low phase holds `scl_oe` at 1 for exactly LCNT+1 cycles, starting with the cycle in which it first goes high.
- R5: When no device holds SCL low, SCL stays released for exactly HCNT+8 cycles between consecutive low phases.
- R6: High-phase counting begins only after `scl_in` is sampled 1. If the line is held low for S extra cycles after release, the released time is S+HCNT+8 cycles. `high_strobe` never fires while `scl_oe` is 1.
- R7: `speed_sel` (0 = standard pair, 1 = fast pair) is sampled when a low phase begins and is held for that whole period. A change in mid-period takes effect with the next period.
- R8: In each low phase, `low_strobe` pulses once, at elapsed cycle floor(LCNT/2) counted from 0. In each counted high phase, `high_strobe` pulses once, at elapsed cycle floor((HCNT+7)/2). The two strobes are never high together.
- R9: `run` is examined only in IDLE and at the end of a high phase. Dropping it in mid-period completes the current period and then leaves SCL released. A new low phase starts only when `run` and `enable` were both 1 at the edge before it.
- R10: When `enable` is 0 at a clock edge, `scl_oe` is 0 from the next cycle on and the controller returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; count registers are writable only while it is low |
| run | input | 1 | Request to keep generating SCL periods |
| speed_sel | input | 1 | 0 selects the standard pair, 1 selects the fast pair |
| cfg_we | input | 1 | Count register write strobe |
| cfg_idx | input | 2 | Count register index |
| cfg_wdata | input | CNT_W | Count register write data |
| scl_in | input | 1 | Sampled level of the SCL wire |
| scl_oe | output | 1 | 1 pulls SCL low |
| low_strobe | output | 1 | Midpoint pulse of the low phase |
| high_strobe | output | 1 | Midpoint pulse of the counted high phase |

## Verification
The assertions and the reference model assume that `scl_in` is already synchronous to `clk`. The bench meets this by forming the wire level from the design's own `scl_oe` and a bench-side stretch request, both of which change away from the rising edge. The assertions also assume that `enable`, `run`, `speed_sel` and the configuration inputs change only between rising edges. The bench drives all of them on the falling edge. Stretching is applied only right after a release, which is the only time a real slow device can hold the line.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_LOW       = 2'd1,
        PH_WAIT_HIGH = 2'd2,
        PH_HIGH      = 2'd3
    } scl_phase_e;

    localparam int NUM_COUNT_REGS = 4;
    localparam int IDX_STD_HIGH   = 0;
    localparam int IDX_STD_LOW    = 1;
    localparam int IDX_FAST_HIGH  = 2;
    localparam int IDX_FAST_LOW   = 3;

    // total released cycles = count + HIGH_OVERHEAD (one seen-high cycle included)
    localparam int HIGH_OVERHEAD  = 8;
    localparam int HIGH_SEEN_CYC  = 1;
    // total driven-low cycles = count + LOW_OVERHEAD
    localparam int LOW_OVERHEAD   = 1;

    // timing targets in tenths of a microsecond
    localparam int T_FALL         = 3;
    localparam int T_STD_HIGH     = 40;
    localparam int T_STD_LOW      = 47;
    localparam int T_FAST_HIGH    = 6;
    localparam int T_FAST_LOW     = 13;
    localparam int HIGH_ADJUST    = 3;
    localparam int LOW_ADJUST     = 1;

    function automatic int round_cycles(input int clk_khz, input int tenths, input int adjust);
        int v;
        v = (clk_khz * tenths + 5000) / 10000 - adjust;
        return (v < 0) ? 0 : v;
    endfunction

    function automatic int default_count(input int clk_khz, input int idx);
        int v;
        case (idx)
            IDX_STD_HIGH:  v = round_cycles(clk_khz, T_STD_HIGH + T_FALL, HIGH_ADJUST);
            IDX_STD_LOW:   v = round_cycles(clk_khz, T_STD_LOW + T_FALL, LOW_ADJUST);
            IDX_FAST_HIGH: v = round_cycles(clk_khz, T_FAST_HIGH + T_FALL, HIGH_ADJUST);
            default:       v = round_cycles(clk_khz, T_FAST_LOW + T_FALL, LOW_ADJUST);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/scl_count_bank.sv
module scl_count_bank
    import scl_gen_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CLK_KHZ = 125000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_idx,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             locked,
    input  logic             fast_sel,
    output logic [CNT_W-1:0] hcnt,
    output logic [CNT_W-1:0] lcnt
);

    logic [CNT_W-1:0] count_val [NUM_COUNT_REGS];

    generate
        for (genvar g = 0; g < NUM_COUNT_REGS; g++) begin : g_cnt
            localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(default_count(CLK_KHZ, g));
            logic [CNT_W-1:0] val_q;
            logic             hit;

            assign hit = wr_en && !locked && (wr_idx == 2'(g));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= RST_VAL;
                end else if (hit) begin
                    val_q <= wr_data;
                end
            end

            assign count_val[g] = val_q;
        end
    endgenerate

    assign hcnt = fast_sel ? count_val[IDX_FAST_HIGH] : count_val[IDX_STD_HIGH];
    assign lcnt = fast_sel ? count_val[IDX_FAST_LOW]  : count_val[IDX_STD_LOW];

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic             speed_sel,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [CNT_W-1:0] lcnt,
    output logic             mode_q,
    output logic             scl_oe,
    output logic             low_strobe,
    output logic             high_strobe
);

    localparam int CW = CNT_W + 1;
    localparam int HIGH_COUNTED = HIGH_OVERHEAD - HIGH_SEEN_CYC;   // cycles in PH_HIGH beyond hcnt

    scl_phase_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          mode_d;

    logic [CW-1:0] low_last, low_mid, high_last, high_mid;
    logic          start_low;

    assign low_last  = {1'b0, lcnt} + CW'(LOW_OVERHEAD - 1);
    assign low_mid   = {1'b0, lcnt} >> 1;
    assign high_last = {1'b0, hcnt} + CW'(HIGH_COUNTED - 1);
    assign high_mid  = ({1'b0, hcnt} + CW'(HIGH_COUNTED)) >> 1;
    assign start_low = enable && run;

    // next state, counter and mode latch
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        mode_d  = mode_q;
        if (!enable) begin
            state_d = PH_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    if (start_low) begin
                        state_d = PH_LOW;
                        cnt_d   = '0;
                        mode_d  = speed_sel;
                    end
                end
                PH_LOW: begin
                    if (cnt_q == low_last) begin
                        state_d = PH_WAIT_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_WAIT_HIGH: begin
                    if (scl_in) begin
                        state_d = PH_HIGH;
                        cnt_d   = '0;
                    end
                end
                PH_HIGH: begin
                    if (cnt_q == high_last) begin
                        cnt_d = '0;
                        if (start_low) begin
                            state_d = PH_LOW;
                            mode_d  = speed_sel;
                        end else begin
                            state_d = PH_IDLE;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = PH_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            mode_q  <= mode_d;
        end
    end

    // outputs
    always_comb begin
        scl_oe      = 1'b0;
        low_strobe  = 1'b0;
        high_strobe = 1'b0;
        unique case (state_q)
            PH_LOW: begin
                scl_oe     = 1'b1;
                low_strobe = (cnt_q == low_mid);
            end
            PH_HIGH: begin
                high_strobe = (cnt_q == high_mid);
            end
            default: begin
                scl_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CLK_KHZ = 125000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic             speed_sel,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_idx,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             low_strobe,
    output logic             high_strobe
);

    logic [CNT_W-1:0] hcnt_sel;
    logic [CNT_W-1:0] lcnt_sel;
    logic             mode_q;

    scl_count_bank #(
        .CNT_W   (CNT_W),
        .CLK_KHZ (CLK_KHZ)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_data  (cfg_wdata),
        .locked   (enable),
        .fast_sel (mode_q),
        .hcnt     (hcnt_sel),
        .lcnt     (lcnt_sel)
    );

    scl_phase_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .run         (run),
        .speed_sel   (speed_sel),
        .scl_in      (scl_in),
        .hcnt        (hcnt_sel),
        .lcnt        (lcnt_sel),
        .mode_q      (mode_q),
        .scl_oe      (scl_oe),
        .low_strobe  (low_strobe),
        .high_strobe (high_strobe)
    );

endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic run,
    input logic scl_oe,
    input logic low_strobe,
    input logic high_strobe
);

    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_oe) else $error("AST_DISABLE_RELEASES"); // R10

    AST_LOW_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> $past(run && enable)) else $error("AST_LOW_NEEDS_RUN"); // R9

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(low_strobe && high_strobe)) else $error("AST_STROBES_EXCLUSIVE"); // R8

    AST_LOW_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        low_strobe |-> scl_oe) else $error("AST_LOW_STROBE_DRIVEN"); // R8

    AST_HIGH_STROBE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        high_strobe |-> !scl_oe) else $error("AST_HIGH_STROBE_RELEASED"); // R6

endmodule

bind scl_period_gen scl_period_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .run         (run),
    .scl_oe      (scl_oe),
    .low_strobe  (low_strobe),
    .high_strobe (high_strobe)
);

// File: tb/scl_period_gen_test.sv
`timescale 1ns/1ps
module scl_period_gen_test;

    localparam int CNT_W = 16;
    localparam int CLK_KHZ = 10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, run = 1'b0, speed_sel = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_idx = '0;
    logic [CNT_W-1:0] cfg_wdata = '0;
    logic stretch = 1'b0;
    logic scl_line;
    logic scl_oe, low_strobe, high_strobe;

    int n_checks = 0, n_fail = 0, cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign scl_line = ~(scl_oe | stretch);

    scl_period_gen #(.CNT_W(CNT_W), .CLK_KHZ(CLK_KHZ)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .speed_sel(speed_sel),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .scl_in(scl_line),
        .scl_oe(scl_oe), .low_strobe(low_strobe), .high_strobe(high_strobe)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model (R3 defaults, R4..R10 timing) ----------------
    int regs [4];
    int m_ph = 0;    // 0 idle, 1 low, 2 released waiting, 3 high counted
    int m_el = 0;
    int m_sel = 0;
    bit started = 0;

    function automatic int rounding(input int tenths, input int adj);
        return (CLK_KHZ * tenths + 5000) / 10000 - adj;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            regs[0] = rounding(43, 3); regs[1] = rounding(50, 1);
            regs[2] = rounding(9, 3);  regs[3] = rounding(16, 1);
            m_ph = 0; m_el = 0; m_sel = 0;
        end else begin
            int hc, lc;
            bit line_up;
            line_up = !stretch && (m_ph != 1);
            hc = regs[m_sel * 2];
            lc = regs[m_sel * 2 + 1];
            if (!enable) begin
                m_ph = 0; m_el = 0;
            end else if (m_ph == 0) begin
                if (run) begin m_ph = 1; m_el = 0; m_sel = speed_sel; end
            end else if (m_ph == 1) begin
                if (m_el >= lc) begin m_ph = 2; m_el = 0; end else m_el++;
            end else if (m_ph == 2) begin
                if (line_up) begin m_ph = 3; m_el = 0; end
            end else begin
                if (m_el >= hc + 6) begin
                    m_el = 0;
                    if (run) begin m_ph = 1; m_sel = speed_sel; end else m_ph = 0;
                end else m_el++;
            end
            if (cfg_we && !enable) regs[cfg_idx] = int'(cfg_wdata);
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started) begin
            int hc, lc;
            hc = regs[m_sel * 2];
            lc = regs[m_sel * 2 + 1];
            check("R4", "scl_oe per cycle", int'(scl_oe), int'(m_ph == 1));
            check("R8", "low_strobe per cycle", int'(low_strobe), int'(m_ph == 1 && m_el == lc / 2));
            check("R8", "high_strobe per cycle", int'(high_strobe), int'(m_ph == 3 && m_el == (hc + 7) / 2));
        end
    end

    // ---------------- phase length monitor ----------------
    int low_q[$];
    int rel_q[$];
    int lowrun = 0, relrun = 0;
    bit prev_oe = 0, seen_low = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_oe && !prev_oe) begin
                if (seen_low) rel_q.push_back(relrun);
                lowrun = 1;
            end else if (!scl_oe && prev_oe) begin
                low_q.push_back(lowrun);
                seen_low = 1;
                relrun = 1;
            end else if (scl_oe) lowrun++;
            else relrun++;
            prev_oe = scl_oe;
        end
    end

    // runs n periods from idle; optional speed flip after the first rise, optional stretch after first release
    task automatic run_seg(input int n, input bit flip, input int st);
        @(posedge clk);
        low_q.delete(); rel_q.delete(); seen_low = 0;
        @(negedge clk);
        run = 1'b1;
        for (int k = 0; k < n; k++) begin
            do @(negedge clk); while (!scl_oe);
            if (k == 0 && flip) speed_sel = ~speed_sel;
            if (k == n - 1) run = 1'b0;
            do @(negedge clk); while (scl_oe);
            if (k == 0 && st > 0) begin
                stretch = 1'b1;
                repeat (st) @(negedge clk);
                stretch = 1'b0;
            end
        end
        repeat (70) @(negedge clk);
    endtask

    task automatic write_reg(input int idx, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = CNT_W'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", "scl_oe in reset", int'(scl_oe), 0);
        check("R1", "strobes in reset", int'(low_strobe | high_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "scl_oe after reset", int'(scl_oe), 0);

        // R3 defaults: std high 40, std low 49
        enable = 1'b1;
        run_seg(2, 0, 0);
        check("R3", "default low periods", low_q.size(), 2);
        foreach (low_q[i]) check("R3", "default std low length", low_q[i], 50);
        check("R3", "default std released length", rel_q[0], 48);
        check("R9", "stopped released", int'(scl_oe), 0);

        // R2: program while disabled
        enable = 1'b0;
        write_reg(0, 3); write_reg(1, 5); write_reg(2, 1); write_reg(3, 2);
        @(negedge clk);
        enable = 1'b1;
        run_seg(3, 0, 0);
        check("R9", "periods after run drop", low_q.size(), 3);
        foreach (low_q[i]) check("R4", "std low length", low_q[i], 6);
        foreach (rel_q[i]) check("R5", "std released length", rel_q[i], 11);

        // R7: flip speed mid period
        run_seg(3, 1, 0);
        check("R7", "low kept std in flip period", low_q[0], 6);
        check("R7", "high kept std in flip period", rel_q[0], 11);
        check("R7", "fast low next period", low_q[1], 3);
        check("R7", "fast released next period", rel_q[1], 9);
        check("R7", "fast low third period", low_q[2], 3);

        // R6: clock stretching of 7 cycles in fast mode
        run_seg(2, 0, 7);
        check("R6", "stretched released length", rel_q[0], 7 + 1 + 8);
        check("R6", "low after stretch", low_q[1], 3);

        // R2: write while enabled ignored
        write_reg(3, 20);
        run_seg(2, 0, 0);
        foreach (low_q[i]) check("R2", "locked write ignored", low_q[i], 3);

        // R10: disable in mid low phase
        @(negedge clk);
        run = 1'b1;
        do @(negedge clk); while (!scl_oe);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R10", "released after disable", int'(scl_oe), 0);
        repeat (10) @(negedge clk);
        check("R10", "stays released while disabled", int'(scl_oe), 0);
        run = 1'b0;
        repeat (5) @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule